// File: doc/BRIEF.md
# On-Chip Bus Region Decoder

This block sits between the 16-bit data port of a processor and three targets: a 2 KB on-chip extension RAM, a window of peripheral registers and the external memory interface. Each request carries a 24-bit byte address, read or write strobes, a size flag (byte or word) and write data. The block picks the target from the address and from one peripheral-enable configuration bit. It inserts the wait states that the chosen target needs, drives the byte-lane enables and returns ready and read data.

While the peripheral is enabled, only the low four segment lines (address bits 16 to 19) reach external memory, and bits 20 to 23 are driven to zero. The RAM arrays, the peripheral and the external bus timing engine are outside this block. They appear only as select, data and completion ports. Requests are taken one at a time: while a transfer is in flight the block reports busy and ignores new strobes.

Top module: `bus_region_dec`

## Requirements
- R1: With periph_en_i = 1, an access to 0x00E000..0x00E7FF asserts xram_sel_o only (ext_sel_o and peri_sel_o stay low).
- R2: With periph_en_i = 0, an access to 0x00E000..0x00E7FF, or to any other address outside both windows, asserts ext_sel_o only.
- R3: With periph_en_i = 1, an access to 0x00EF00..0x00EFFF asserts peri_sel_o only. With periph_en_i = 0 the same addresses go to ext_sel_o.
- R4: An extension RAM access has zero wait states. If the request is sampled at clock edge E, ready_o is high in the cycle right after E.
- R5: A peripheral access has exactly two wait states. ready_o is low in the first two cycles after the accepting edge and high in the third.
- R6: An external access completes in the first active cycle in which ext_done_i is high. ext_addr_o equals the address with bits 23..20 forced to 0 when periph_en_i was 1 at acceptance, and the full address otherwise.
- R7: be_o[0] is the low byte lane (bits 7:0) and be_o[1] is the high lane. A word access gives be_o = 2'b11, a byte access at an even address gives 2'b01, and a byte access at an odd address gives 2'b10.
- R8: A word request at an odd address starts no transfer (no select, busy_o stays 0) and raises misalign_o for exactly the one cycle after the request edge.
- R9: rdata_o carries the selected target's read data during the ready cycle. For a write, we_o is high and wdata_o carries the request's write data while the target is selected.
- R10: busy_o is high from the accepting edge to the end of the ready cycle. ready_o is a single-cycle pulse. A request that arrives while busy_o is high is dropped and produces no later select.
- R11: After reset, busy_o, ready_o, misalign_o and all selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| periph_en_i | input | 1 | Configuration bit enabling both on-chip windows |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| xram_rdata_i | input | 16 | Extension RAM read data |
| peri_rdata_i | input | 16 | Peripheral read data |
| ext_rdata_i | input | 16 | External interface read data |
| ext_done_i | input | 1 | External interface completion |
| xram_sel_o | output | 1 | Extension RAM select |
| peri_sel_o | output | 1 | Peripheral window select |
| ext_sel_o | output | 1 | External interface select |
| tgt_addr_o | output | 24 | Latched byte address toward on-chip targets |
| ext_addr_o | output | 24 | Address toward external memory with segment masking |
| be_o | output | 2 | Byte-lane enables |
| we_o | output | 1 | Write enable toward target |
| wdata_o | output | 16 | Write data toward target |
| rdata_o | output | 16 | Read data returned to processor |
| ready_o | output | 1 | Transfer complete pulse |
| busy_o | output | 1 | Transfer in flight, requests ignored |
| misalign_o | output | 1 | Misaligned word request pulse |

## Verification
Each target is reached with byte-even, byte-odd and word requests, both reads and writes. This separates the lane encoding from the region choice and shows that every target returns its own data. The same addresses are then issued with the enable bit cleared, which shows that the gating falls through to external memory and is not an address-only decode. The first and last addresses of both windows, and addresses just outside them, catch off-by-one errors in the window limits. High-segment external addresses are run with the enable set and cleared to expose the masking. A peripheral access with a second request injected during its wait states, and a misaligned word, show that held-off and rejected requests leave no trace.

// File: rtl/bus_region_pkg.sv
package bus_region_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_XRAM = 2'd1,
    RG_PERI = 2'd2,
    RG_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import bus_region_pkg::*;
#(
  parameter int unsigned       AW        = 24,
  parameter logic [AW-1:0]     XRAM_BASE = 24'h00E000,
  parameter int unsigned       XRAM_SIZE = 2048,
  parameter logic [AW-1:0]     PERI_BASE = 24'h00EF00,
  parameter int unsigned       PERI_SIZE = 256
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output region_e       region_o
);
  localparam logic [AW-1:0] XRAM_LAST = XRAM_BASE + AW'(XRAM_SIZE - 1);
  localparam logic [AW-1:0] PERI_LAST = PERI_BASE + AW'(PERI_SIZE - 1);

  logic hit_xram, hit_peri;
  assign hit_xram = (addr_i >= XRAM_BASE) && (addr_i <= XRAM_LAST);
  assign hit_peri = (addr_i >= PERI_BASE) && (addr_i <= PERI_LAST);

  always_comb begin
    if (en_i && hit_xram)      region_o = RG_XRAM;
    else if (en_i && hit_peri) region_o = RG_PERI;
    else                       region_o = RG_EXT;
  end
endmodule

// File: rtl/lane_gen.sv
module lane_gen #(
  parameter int unsigned NB = 2
) (
  input  logic          lsb_i,
  input  logic          word_i,
  output logic [NB-1:0] be_o,
  output logic          misalign_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be_o[i] = word_i || (lsb_i == i[0]);
  end
  assign misalign_o = word_i && lsb_i;
endmodule

// File: rtl/wait_seq.sv
module wait_seq
  import bus_region_pkg::*;
#(
  parameter int unsigned XRAM_WAITS = 0,
  parameter int unsigned PERI_WAITS = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    accept_i,
  input  region_e region_i,
  input  logic    ext_done_i,
  output logic    active_o,
  output logic    ready_o,
  output region_e region_o
);
  localparam int unsigned MAXW = (PERI_WAITS > XRAM_WAITS) ? PERI_WAITS : XRAM_WAITS;
  localparam int unsigned CW   = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  region_e       region_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      region_q <= RG_NONE;
    end else if (accept_i) begin
      active_q <= 1'b1;
      region_q <= region_i;
      cnt_q    <= (region_i == RG_PERI) ? CW'(PERI_WAITS) :
                  (region_i == RG_XRAM) ? CW'(XRAM_WAITS) : '0;
    end else if (active_q) begin
      if (ready_o) begin
        active_q <= 1'b0;
        region_q <= RG_NONE;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign region_o = region_q;
  assign ready_o  = active_q && (cnt_q == '0) && ((region_q != RG_EXT) || ext_done_i);

  // checker: cycles since acceptance vs. the wait count for the region
  logic [7:0] age_q, lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      lat_q <= '0;
    end else if (accept_i) begin
      age_q <= '0;
      lat_q <= (region_i == RG_PERI) ? 8'(PERI_WAITS) :
               (region_i == RG_XRAM) ? 8'(XRAM_WAITS) : 8'd0;
    end else if (active_q && age_q != 8'hff) begin
      age_q <= age_q + 1'b1;
    end
  end

  p_wait_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && region_q != RG_EXT |-> age_q == lat_q);
  p_xram_zero_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && region_i == RG_XRAM && XRAM_WAITS == 0 |=> ready_o);
  p_ready_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/bus_region_dec.sv
module bus_region_dec
  import bus_region_pkg::*;
#(
  parameter int unsigned AW         = 24,
  parameter int unsigned DW         = 16,
  parameter int unsigned SEG_KEEP   = 20,
  parameter int unsigned XRAM_WAITS = 0,
  parameter int unsigned PERI_WAITS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            periph_en_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            word_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   xram_rdata_i,
  input  logic [DW-1:0]   peri_rdata_i,
  input  logic [DW-1:0]   ext_rdata_i,
  input  logic            ext_done_i,
  output logic            xram_sel_o,
  output logic            peri_sel_o,
  output logic            ext_sel_o,
  output logic [AW-1:0]   tgt_addr_o,
  output logic [AW-1:0]   ext_addr_o,
  output logic [DW/8-1:0] be_o,
  output logic            we_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   rdata_o,
  output logic            ready_o,
  output logic            busy_o,
  output logic            misalign_o
);
  localparam int unsigned NB = DW / 8;

  region_e       region_d, region_q;
  logic [NB-1:0] be_d, be_q;
  logic          mis_d, mis_q, active, req, accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, en_q;

  region_decode #(.AW(AW)) u_dec (
    .addr_i  (addr_i),
    .en_i    (periph_en_i),
    .region_o(region_d)
  );

  lane_gen #(.NB(NB)) u_lane (
    .lsb_i     (addr_i[0]),
    .word_i    (word_i),
    .be_o      (be_d),
    .misalign_o(mis_d)
  );

  assign req    = rd_i || wr_i;
  assign accept = req && !active && !mis_d;

  wait_seq #(.XRAM_WAITS(XRAM_WAITS), .PERI_WAITS(PERI_WAITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .region_i  (region_d),
    .ext_done_i(ext_done_i),
    .active_o  (active),
    .ready_o   (ready_o),
    .region_o  (region_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      en_q    <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      mis_q <= req && !active && mis_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_d;
        we_q    <= wr_i;
        en_q    <= periph_en_i;
      end
    end
  end

  assign xram_sel_o = active && (region_q == RG_XRAM);
  assign peri_sel_o = active && (region_q == RG_PERI);
  assign ext_sel_o  = active && (region_q == RG_EXT);
  assign tgt_addr_o = addr_q;
  assign ext_addr_o = en_q ? {{(AW-SEG_KEEP){1'b0}}, addr_q[SEG_KEEP-1:0]} : addr_q;
  assign be_o       = active ? be_q : '0;
  assign we_o       = active && we_q;
  assign wdata_o    = wdata_q;
  assign busy_o     = active;
  assign misalign_o = mis_q;

  always_comb begin
    rdata_o = '0;
    if (ready_o) begin
      case (region_q)
        RG_XRAM: rdata_o = xram_rdata_i;
        RG_PERI: rdata_o = peri_rdata_i;
        RG_EXT:  rdata_o = ext_rdata_i;
        default: rdata_o = '0;
      endcase
    end
  end

  p_one_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xram_sel_o, peri_sel_o, ext_sel_o}));
  p_ext_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_o && en_q |-> ext_addr_o[AW-1:SEG_KEEP] == '0);
  p_misalign_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !busy_o && $past(req));
  p_lanes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> be_o != '0);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ready_o |=> busy_o && $stable(tgt_addr_o));
endmodule

// File: tb/sim_bus_region_dec.sv
module sim_bus_region_dec;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b1, rd = 1'b0, wr = 1'b0, word = 1'b0, ext_done = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        xsel, psel, esel, we, ready, busy, mis;
  logic [23:0] taddr, eaddr;
  logic [1:0]  be;
  logic [15:0] wdo, rdata;
  int          total = 0, bad = 0;

  localparam logic [15:0] XD = 16'hA1A1, PD = 16'hB2B2, ED = 16'hC3C3;

  always #4 clk = ~clk;

  bus_region_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .periph_en_i(en), .rd_i(rd), .wr_i(wr),
    .word_i(word), .addr_i(addr), .wdata_i(wdata), .xram_rdata_i(XD),
    .peri_rdata_i(PD), .ext_rdata_i(ED), .ext_done_i(ext_done),
    .xram_sel_o(xsel), .peri_sel_o(psel), .ext_sel_o(esel), .tgt_addr_o(taddr),
    .ext_addr_o(eaddr), .be_o(be), .we_o(we), .wdata_o(wdo), .rdata_o(rdata),
    .ready_o(ready), .busy_o(busy), .misalign_o(mis)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // region code: 1 xram, 2 peri, 3 ext; lat = cycle index of ready
  task automatic run_acc(input logic [23:0] a, input bit w, input bit wrt, input bit e,
                         input int reg_exp, input int lat, input logic [1:0] be_exp,
                         input logic [23:0] eaddr_exp, input string tag);
    int k;
    logic [2:0] sels;
    @(posedge clk); #1;
    addr = a; word = w; rd = !wrt; wr = wrt; en = e; wdata = a[15:0] ^ 16'h5A5A;
    @(posedge clk); #1;
    rd = 0; wr = 0;
    k = 1;
    ext_done = (reg_exp == 3) && (k >= lat);
    @(negedge clk);
    sels = {esel, psel, xsel};
    chk(sels == 3'b001 << (reg_exp - 1), {tag, " R1 R2 R3 select"}, 32'(sels), 32'(3'b001 << (reg_exp - 1)));
    chk(be == be_exp, {tag, " R7 lanes"}, 32'(be), 32'(be_exp));
    chk(busy, {tag, " R10 busy"}, 32'(busy), 1);
    if (reg_exp == 3) chk(eaddr == eaddr_exp, {tag, " R6 ext addr"}, eaddr, eaddr_exp);
    else chk(taddr == a, {tag, " R9 tgt addr"}, taddr, a);
    if (wrt) chk(we && wdo == (a[15:0] ^ 16'h5A5A), {tag, " R9 write"}, 32'(wdo), 32'(a[15:0] ^ 16'h5A5A));
    else chk(!we, {tag, " R9 no we"}, 32'(we), 0);
    while (!ready && k < 20) begin
      @(posedge clk); #1;
      k++;
      ext_done = (reg_exp == 3) && (k >= lat);
      @(negedge clk);
    end
    chk(k == lat, {tag, " R4 R5 R6 wait cycles"}, k, lat);
    if (!wrt) chk(rdata == (reg_exp == 1 ? XD : reg_exp == 2 ? PD : ED), {tag, " R9 rdata"},
                  32'(rdata), 32'(reg_exp == 1 ? XD : reg_exp == 2 ? PD : ED));
    @(posedge clk); #1;
    ext_done = 0;
    @(negedge clk);
    chk(!ready && !busy, {tag, " R10 pulse end"}, {30'd0, ready, busy}, 0);
  endtask

  task automatic t_reset;
    chk({xsel, psel, esel, ready, busy, mis} == 6'b0, "R11 reset", 32'({xsel, psel, esel, ready, busy, mis}), 0);
  endtask

  task automatic t_windows;
    run_acc(24'h00E000, 1, 0, 1, 1, 1, 2'b11, 24'h0, "xram lo word rd");
    run_acc(24'h00E7FF, 0, 1, 1, 1, 1, 2'b10, 24'h0, "xram hi byte wr");
    run_acc(24'h00E402, 0, 0, 1, 1, 1, 2'b01, 24'h0, "xram even byte");
    run_acc(24'h00E800, 1, 0, 1, 3, 1, 2'b11, 24'h00E800, "above xram");
    run_acc(24'h00DFFE, 1, 1, 1, 3, 2, 2'b11, 24'h00DFFE, "below xram");
    run_acc(24'h00EF00, 1, 0, 1, 2, 3, 2'b11, 24'h0, "peri lo");
    run_acc(24'h00EFFF, 0, 1, 1, 2, 3, 2'b10, 24'h0, "peri hi");
    run_acc(24'h00EEFF, 0, 0, 1, 3, 1, 2'b10, 24'h00EEFF, "below peri");
  endtask

  task automatic t_disabled;
    run_acc(24'h00E010, 1, 0, 0, 3, 2, 2'b11, 24'h00E010, "R2 xram disabled");
    run_acc(24'h00EF20, 0, 0, 0, 3, 1, 2'b01, 24'h00EF20, "R3 peri disabled");
  endtask

  task automatic t_segments;
    run_acc(24'hA52344, 1, 0, 1, 3, 4, 2'b11, 24'h052344, "R6 masked");
    run_acc(24'hA52345, 0, 1, 0, 3, 3, 2'b10, 24'hA52345, "R6 full");
  endtask

  task automatic t_misalign;
    @(posedge clk); #1;
    addr = 24'h00E003; word = 1; rd = 1; en = 1;
    @(posedge clk); #1;
    rd = 0;
    @(negedge clk);
    chk(mis && !busy && !xsel && !esel, "R8 misalign pulse", {28'd0, mis, busy, xsel, esel}, 32'h8);
    @(negedge clk);
    chk(!mis && !busy, "R8 pulse one cycle", {30'd0, mis, busy}, 0);
  endtask

  task automatic t_busy;
    int k;
    @(posedge clk); #1;
    addr = 24'h00EF10; word = 1; rd = 1; en = 1;
    @(posedge clk); #1;
    addr = 24'h00E100; word = 0;     // second request during wait states
    k = 1;
    @(posedge clk); #1;
    rd = 0;
    k = 2;
    @(negedge clk);
    chk(psel && !xsel && taddr == 24'h00EF10, "R10 held off", {xsel, taddr}, 24'h00EF10);
    @(negedge clk);
    chk(ready && rdata == PD, "R10 R5 first completes", 32'(rdata), 32'(PD));
    @(negedge clk);
    chk(!busy && !xsel && !ready, "R10 dropped request", {29'd0, busy, xsel, ready}, 0);
  endtask

  initial begin
    #(8 * 50000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_windows;
    t_disabled;
    t_segments;
    t_misalign;
    t_busy;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule